// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Register Bank

This block is a small bank of 16-bit control and status registers for a network controller. Software reaches it through a port with a register address and separate read and write strobes. Hardware units outside the block, such as the MAC, the transceiver and the descriptor engine, report events on one input line per event. Each line sets a sticky status flag on its rising edge. Software clears a flag by writing a one to its bit. Each flag has a mask bit, and every mask bit powers up set. The flags that are not masked are ORed into a summary flag. The interrupt request is that summary flag gated by a global enable bit.

The bank also holds two 4-bit ring-length fields and a 64-bit multicast address filter split into four 16-bit words. All of these are visible only while the controller sits in its stopped state. The ring lengths can be loaded only through an internal initialization-load port. The filter words can also be written by software while the controller is stopped. Writing the stop bit as one clears every status flag and leaves the masks untouched.

Top module: `nic_csr_bank`

## Requirements
- R1: After reset all flags are 0, all mask bits are 1, stop is 1, the enable is 0, `irq_o` is 0 and `rdata_o` is 0, so a read of address 0 returns 0x0001 and a read of address 2 returns 0x000F.
- R2: Flag bit i (address 1, bit i) is set in the cycle after a 0-to-1 transition of `evt_i[i]`. An input held high does not set the flag again once software has cleared it.
- R3: A write to address 1 clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If a rising edge of an event arrives in the same cycle as a write-one clear of its flag, the flag ends up set.
- R5: A write to address 0 with bit 0 set to 1 sets stop and clears every flag, even one whose event rises in that cycle. The mask register (address 2, read/write at any time) is not changed by it.
- R6: Address 0 holds stop in bit 0 and the interrupt enable in bit 1, both read/write. Bit 7 is the read-only summary, which is 1 when any flag is set whose mask bit is 0. All other bits read 0.
- R7: `irq_o` is 1 exactly when the enable bit is 1 and the summary is 1.
- R8: While stop is 1, address 3 reads the transmit ring length in bits 15:12, the receive ring length in bits 11:8, and 0 in bits 7:0. It reads 0 while stop is 0. Software writes to it have no effect. `init_ld_i` loads both fields.
- R9: Addresses 4 to 7 hold filter bits 15:0, 31:16, 47:32 and 63:48 in that order. They are read/write only while stop is 1 (checked against the stop value before the write). Otherwise they read 0 and writes are ignored. `init_ld_i` loads all four words and takes precedence over a software write in the same cycle.
- R10: `rdata_o` presents the register selected when `rd_en_i` was high, as it stood before any write in that same cycle, one cycle later. It holds its value while `rd_en_i` is low. Addresses 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| evt_i | input | NUM_EVT | Event lines from hardware units |
| init_ld_i | input | 1 | Initialization load strobe |
| init_txlen_i | input | 4 | Transmit ring length to load |
| init_rxlen_i | input | 4 | Receive ring length to load |
| init_filt_i | input | 64 | Address filter image to load |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following rules:
- Flags change only through an event edge, a one-clear or the stop clear.
- An event edge wins over a same-cycle clear.
- A stop write empties the flags and keeps the masks.
- The request never rises without the enable and an unmasked flag.
- Reads of the hidden registers while running return zero, and read data holds between reads.

Only the bench scenarios can show the following: the actual register contents returned at each address, the ring-length field positions, the order of the filter words, precedence of an initialization load over a same-cycle write, and a level-held event not re-setting a cleared flag.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_FLAG  = 1;
    localparam int ADR_MASK  = 2;
    localparam int ADR_RING  = 3;
    localparam int ADR_FILT  = 4;

    localparam int CTRL_STOP = 0;
    localparam int CTRL_IEN  = 1;
    localparam int CTRL_SUM  = 7;

    localparam int LEN_W     = 4;
    localparam int TX_LSB    = 12;
    localparam int RX_LSB    = 8;

    typedef struct packed {
        logic stop;
        logic ien;
    } ctrl_t;
endpackage

// File: rtl/csr_evt_flags.sv
module csr_evt_flags #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic         clr_all_i,
    input  logic [N-1:0] w1c_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_wdata_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] rise_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flags;
        logic [N-1:0] mask;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] rise;
    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = evt_i[i] & ~st_q.prev[i];
        assign live[i] = st_q.flags[i] & ~st_q.mask[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt_i;
        if (clr_all_i) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = (st_q.flags & ~w1c_i) | rise;
        end
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev  <= '0;
            st_q.flags <= '0;
            st_q.mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign mask_o  = st_q.mask;
    assign rise_o  = rise;
    assign pend_o  = |live;
endmodule

// File: rtl/csr_cfg_store.sv
module csr_cfg_store #(
    parameter int DATA_W     = 16,
    parameter int FILT_WORDS = 4,
    parameter int LEN_W      = 4,
    localparam int IDX_W     = (FILT_WORDS > 1) ? $clog2(FILT_WORDS) : 1,
    localparam int FILT_W    = FILT_WORDS * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              init_ld_i,
    input  logic [LEN_W-1:0]  init_txlen_i,
    input  logic [LEN_W-1:0]  init_rxlen_i,
    input  logic [FILT_W-1:0] init_filt_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LEN_W-1:0]  txlen_o,
    output logic [LEN_W-1:0]  rxlen_o,
    output logic [FILT_W-1:0] filt_o
);
    typedef struct packed {
        logic [LEN_W-1:0]  txlen;
        logic [LEN_W-1:0]  rxlen;
        logic [FILT_W-1:0] filt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int w = 0; w < FILT_WORDS; w++) begin
            if (wr_en_i && (32'(wr_idx_i) == w)) begin
                cfg_d.filt[w*DATA_W +: DATA_W] = wdata_i;
            end
        end
        if (init_ld_i) begin
            cfg_d.txlen = init_txlen_i;
            cfg_d.rxlen = init_rxlen_i;
            cfg_d.filt  = init_filt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign txlen_o = cfg_q.txlen;
    assign rxlen_o = cfg_q.rxlen;
    assign filt_o  = cfg_q.filt;
endmodule

// File: rtl/csr_read_port.sv
module csr_read_port #(
    parameter int N          = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int FILT_WORDS = 4,
    localparam int FILT_W    = FILT_WORDS * DATA_W,
    localparam int LEN_W     = csr_bank_pkg::LEN_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              stop_i,
    input  logic              ien_i,
    input  logic              pend_i,
    input  logic [N-1:0]      flags_i,
    input  logic [N-1:0]      mask_i,
    input  logic [LEN_W-1:0]  txlen_i,
    input  logic [LEN_W-1:0]  rxlen_i,
    input  logic [FILT_W-1:0] filt_i,
    output logic [DATA_W-1:0] rdata_o
);
    import csr_bank_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] sel;
    int unsigned       a;

    always_comb begin
        a   = 32'(addr_i);
        sel = '0;
        if (a == ADR_CTRL) begin
            sel[CTRL_STOP] = stop_i;
            sel[CTRL_IEN]  = ien_i;
            sel[CTRL_SUM]  = pend_i;
        end else if (a == ADR_FLAG) begin
            sel[N-1:0] = flags_i;
        end else if (a == ADR_MASK) begin
            sel[N-1:0] = mask_i;
        end else if (a == ADR_RING) begin
            if (stop_i) begin
                sel[TX_LSB +: LEN_W] = txlen_i;
                sel[RX_LSB +: LEN_W] = rxlen_i;
            end
        end else begin
            for (int w = 0; w < FILT_WORDS; w++) begin
                if (stop_i && (a == ADR_FILT + w)) begin
                    sel = filt_i[w*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d.rdata = sel;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;
endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank #(
    parameter int NUM_EVT    = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int FILT_WORDS = 4,
    localparam int LEN_W     = csr_bank_pkg::LEN_W,
    localparam int FILT_W    = FILT_WORDS * DATA_W,
    localparam int IDX_W     = (FILT_WORDS > 1) ? $clog2(FILT_WORDS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              init_ld_i,
    input  logic [LEN_W-1:0]  init_txlen_i,
    input  logic [LEN_W-1:0]  init_rxlen_i,
    input  logic [FILT_W-1:0] init_filt_i,
    output logic              irq_o
);
    import csr_bank_pkg::*;

    ctrl_t ctrl_d, ctrl_q;

    logic               wr_ctrl, wr_flag, wr_mask, wr_filt, stop_set;
    logic [NUM_EVT-1:0] w1c, flags, mask, evt_rise;
    logic               pend;
    logic [IDX_W-1:0]   filt_idx;
    logic [LEN_W-1:0]   txlen, rxlen;
    logic [FILT_W-1:0]  filt;
    logic               stop_now, ien_now;
    int unsigned        a;

    always_comb begin
        a        = 32'(addr_i);
        wr_ctrl  = wr_en_i && (a == ADR_CTRL);
        wr_flag  = wr_en_i && (a == ADR_FLAG);
        wr_mask  = wr_en_i && (a == ADR_MASK);
        wr_filt  = wr_en_i && ctrl_q.stop && (a >= ADR_FILT) && (a < ADR_FILT + FILT_WORDS);
        stop_set = wr_ctrl && wdata_i[CTRL_STOP];
        w1c      = wr_flag ? wdata_i[NUM_EVT-1:0] : '0;
        filt_idx = IDX_W'(a - ADR_FILT);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.stop = wdata_i[CTRL_STOP];
            ctrl_d.ien  = wdata_i[CTRL_IEN];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.stop <= 1'b1;
            ctrl_q.ien  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign stop_now = ctrl_q.stop;
    assign ien_now  = ctrl_q.ien;

    csr_evt_flags #(.N(NUM_EVT)) u_flags (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .evt_i        (evt_i),
        .clr_all_i    (stop_set),
        .w1c_i        (w1c),
        .mask_we_i    (wr_mask),
        .mask_wdata_i (wdata_i[NUM_EVT-1:0]),
        .flags_o      (flags),
        .mask_o       (mask),
        .rise_o       (evt_rise),
        .pend_o       (pend)
    );

    csr_cfg_store #(.DATA_W(DATA_W), .FILT_WORDS(FILT_WORDS), .LEN_W(LEN_W)) u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .init_ld_i    (init_ld_i),
        .init_txlen_i (init_txlen_i),
        .init_rxlen_i (init_rxlen_i),
        .init_filt_i  (init_filt_i),
        .wr_en_i      (wr_filt),
        .wr_idx_i     (filt_idx),
        .wdata_i      (wdata_i),
        .txlen_o      (txlen),
        .rxlen_o      (rxlen),
        .filt_o       (filt)
    );

    csr_read_port #(.N(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_WORDS(FILT_WORDS)) u_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .stop_i  (ctrl_q.stop),
        .ien_i   (ctrl_q.ien),
        .pend_i  (pend),
        .flags_i (flags),
        .mask_i  (mask),
        .txlen_i (txlen),
        .rxlen_i (rxlen),
        .filt_i  (filt),
        .rdata_o (rdata_o)
    );

    assign irq_o = ctrl_q.ien & pend;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
    parameter int N          = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int FILT_WORDS = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic              irq_i,
    input logic [N-1:0]      rise_i,
    input logic [N-1:0]      flags_i,
    input logic [N-1:0]      mask_i,
    input logic              stop_i,
    input logic              ien_i
);
    import csr_bank_pkg::*;

    logic stop_wr, flag_wr, ring_rd, filt_rd;
    assign stop_wr = wr_en_i && (32'(addr_i) == ADR_CTRL) && wdata_i[CTRL_STOP];
    assign flag_wr = wr_en_i && (32'(addr_i) == ADR_FLAG);
    assign ring_rd = rd_en_i && (32'(addr_i) == ADR_RING);
    assign filt_rd = rd_en_i && (32'(addr_i) >= ADR_FILT) && (32'(addr_i) < ADR_FILT + FILT_WORDS);

    // R2
    no_spont_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i == '0) |=> ((flags_i & ~$past(flags_i)) == '0));

    // R3
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_wr |=> ((flags_i & $past(wdata_i[N-1:0]) & ~$past(rise_i)) == '0));

    // R3
    w0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_wr |=> (($past(flags_i) & ~$past(wdata_i[N-1:0]) & ~flags_i) == '0));

    // R4
    evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise_i != '0) && !stop_wr) |=> ((flags_i & $past(rise_i)) == $past(rise_i)));

    // R5
    stop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_wr |=> ((flags_i == '0) && (mask_i == $past(mask_i)) && stop_i));

    // R7
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (ien_i && ((flags_i & ~mask_i) != '0)));

    // R8
    ring_hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ring_rd && !stop_i) |=> (rdata_i == '0));

    // R9
    filt_hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_rd && !stop_i) |=> (rdata_i == '0));

    // R10
    rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_i));
endmodule

bind nic_csr_bank csr_bank_chk #(
    .N(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_WORDS(FILT_WORDS)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rd_en_i (rd_en_i),
    .rdata_i (rdata_o),
    .irq_i   (irq_o),
    .rise_i  (evt_rise),
    .flags_i (flags),
    .mask_i  (mask),
    .stop_i  (stop_now),
    .ien_i   (ien_now)
);

// File: tb/nic_csr_bank_bench.sv
module nic_csr_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic [NE-1:0] evt = '0;
    logic        init_ld = 1'b0;
    logic [3:0]  init_tx = '0;
    logic [3:0]  init_rx = '0;
    logic [63:0] init_filt = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [NE-1:0] m_flags, m_mask, m_prev;
    logic          m_stop, m_ien;
    logic [3:0]    m_tx, m_rx;
    logic [15:0]   m_filt [4];
    logic [15:0]   m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_csr_bank u_nic_csr_bank (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .addr_i       (addr),
        .wr_en_i      (wr_en),
        .wdata_i      (wdata),
        .rd_en_i      (rd_en),
        .rdata_o      (rdata),
        .evt_i        (evt),
        .init_ld_i    (init_ld),
        .init_txlen_i (init_tx),
        .init_rxlen_i (init_rx),
        .init_filt_i  (init_filt),
        .irq_o        (irq)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(int a);
        logic [15:0] v = '0;
        case (a)
            0: begin
                v[0] = m_stop;
                v[1] = m_ien;
                v[7] = |(m_flags & ~m_mask);
            end
            1: v[NE-1:0] = m_flags;
            2: v[NE-1:0] = m_mask;
            3: if (m_stop) v = {m_tx, m_rx, 8'h00};
            4, 5, 6, 7: if (m_stop) v = m_filt[a-4];
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic m_reset();
        m_flags = '0; m_mask = '1; m_prev = '0;
        m_stop = 1'b1; m_ien = 1'b0;
        m_tx = '0; m_rx = '0; m_rdata = '0;
        for (int i = 0; i < 4; i++) m_filt[i] = '0;
    endtask

    task automatic m_step();
        int a = int'(addr);
        logic [NE-1:0] rise = evt & ~m_prev;
        logic [NE-1:0] nf = m_flags;
        if (rd_en) m_rdata = m_read(a);
        if (wr_en && a == 1) nf = nf & ~wdata[NE-1:0];
        nf = nf | rise;
        if (wr_en && a == 0 && wdata[0]) nf = '0;
        m_flags = nf;
        if (wr_en && a == 2) m_mask = wdata[NE-1:0];
        if (wr_en && m_stop && a >= 4 && a <= 7) m_filt[a-4] = wdata;
        if (init_ld) begin
            m_tx = init_tx; m_rx = init_rx;
            for (int i = 0; i < 4; i++) m_filt[i] = init_filt[i*16 +: 16];
        end
        if (wr_en && a == 0) begin
            m_stop = wdata[0];
            m_ien  = wdata[1];
        end
        m_prev = evt;
    endtask

    // one clock: model update at the edge, compare at the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        m_step();
        @(negedge clk);
        chk(tag, rdata, m_rdata);
        chk("R7", {15'b0, irq}, {15'b0, m_ien & (|(m_flags & ~m_mask))});
    endtask

    task automatic wr(int a, logic [15:0] d, string tag);
        addr = 4'(a); wdata = d; wr_en = 1'b1;
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, logic [15:0] exp, string tag);
        addr = 4'(a); rd_en = 1'b1;
        tick(tag);
        rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", rdata, 16'h0000);
        chk("R1", {15'b0, irq}, 16'h0000);
        rd(0, 16'h0001, "R1");
        rd(2, 16'h000F, "R1");
        rd(1, 16'h0000, "R1");

        // run, enable interrupts, flag masked
        wr(0, 16'h0002, "R6");
        evt = 4'b0001; tick("R2");
        evt = 4'b0000; tick("R2");
        rd(1, 16'h0001, "R2");
        chk("R6", {15'b0, irq}, 16'h0000);
        wr(2, 16'h0000, "R6");
        rd(0, 16'h0082, "R6");
        chk("R7", {15'b0, irq}, 16'h0001);

        // level held event does not re-set after clear
        evt = 4'b0010; tick("R2"); tick("R2"); tick("R2");
        wr(1, 16'h0002, "R2");
        tick("R2"); tick("R2");
        rd(1, 16'h0001, "R2");
        evt = 4'b0000; tick("R2");

        // write zero keeps, write one clears
        wr(1, 16'h0000, "R3");
        rd(1, 16'h0001, "R3");
        wr(1, 16'h0001, "R3");
        rd(1, 16'h0000, "R3");
        chk("R3", {15'b0, irq}, 16'h0000);

        // event edge and clear in one cycle
        evt = 4'b0100;
        wr(1, 16'h0004, "R4");
        evt = 4'b0000;
        rd(1, 16'h0004, "R4");
        chk("R4", {15'b0, irq}, 16'h0001);

        // enable gates request
        wr(0, 16'h0000, "R7");
        chk("R7", {15'b0, irq}, 16'h0000);
        wr(0, 16'h0002, "R7");
        chk("R7", {15'b0, irq}, 16'h0001);

        // hidden registers while running
        init_ld = 1'b1; init_tx = 4'h5; init_rx = 4'h3;
        init_filt = 64'h1111_2222_3333_4444;
        tick("R8");
        init_ld = 1'b0;
        rd(3, 16'h0000, "R8");
        rd(4, 16'h0000, "R9");
        wr(4, 16'hDEAD, "R9");

        // stop clears flags, masks kept, rising event dropped
        evt = 4'b1000;
        wr(0, 16'h0001, "R5");
        evt = 4'b0000;
        rd(1, 16'h0000, "R5");
        rd(2, 16'h0000, "R5");
        evt = 4'b0001; tick("R5");
        evt = 4'b0000;
        wr(0, 16'h0001, "R5");
        rd(1, 16'h0000, "R5");

        // ring lengths visible while stopped, write ignored
        rd(3, 16'h5300, "R8");
        wr(3, 16'hFFFF, "R8");
        rd(3, 16'h5300, "R8");

        // filter words
        rd(4, 16'h4444, "R9");
        rd(7, 16'h1111, "R9");
        wr(5, 16'hBEEF, "R9");
        rd(5, 16'hBEEF, "R9");
        init_ld = 1'b1; init_tx = 4'hA; init_rx = 4'hC;
        init_filt = 64'h9999_8888_7777_6666;
        wr(6, 16'hAAAA, "R9");
        init_ld = 1'b0;
        rd(6, 16'h8888, "R9");
        rd(3, 16'hAC00, "R8");

        // read port timing
        rd(9, 16'h0000, "R10");
        rd(0, 16'h0001, "R10");
        tick("R10"); tick("R10");
        chk("R10", rdata, 16'h0001);
        addr = 4'd2; rd_en = 1'b1; wr_en = 1'b1; wdata = 16'h000F;
        tick("R10");
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R10", rdata, 16'h0000);
        rd(2, 16'h000F, "R10");

        // varied event traffic while running
        wr(0, 16'h0002, "R2");
        wr(2, 16'h0005, "R6");
        for (int i = 0; i < 48; i++) begin
            evt = 4'((i * 7) ^ (i >> 1));
            if (i % 5 == 0) begin
                wr(1, 16'(i & 15), "R3");
            end else if (i % 3 == 0) begin
                rd(1, m_read(1), "R2");
            end else begin
                tick("R2");
            end
        end
        evt = '0;
        tick("R2");

        summary();
        $finish;
    end
endmodule